// File: doc/BRIEF.md
# Descriptor-Driven Pattern Address Generator

This block turns a small table of access descriptors into a stream of memory requests. Software first writes descriptors into the table while the block is idle. It then pulses `start` with the index of the first descriptor. The block walks the table and issues one request per element on a valid/ready request port. Each request carries the external address, the local (scratchpad) address and the read/write direction. No data moves through the block. It only produces the sequence of addresses.

A descriptor of the flat kind describes a strided stream on its own. A chain is built from three linked kinds. The end kind stops the walk. The linked kind supplies its own stream base address and names the next descriptor. The ask kind stalls the walk and holds a request to the compute unit until a grant returns the stream base address. The first linked descriptor of a chain (the head) fixes the direction, the starting local address and the element count for every run in that chain. Later descriptors contribute only their stream base, stride and next index.

The control is one state machine with five states: `S_IDLE`, `S_LOAD`, `S_GRANT`, `S_ISSUE` and `S_FINISH`.
- `S_IDLE` waits for `start` and then moves to `S_LOAD`.
- `S_LOAD` decodes the current descriptor. It moves to `S_ISSUE` for a run with elements, to `S_GRANT` for an ask descriptor, back to `S_LOAD` for a linked run of zero elements, or to `S_FINISH` on termination.
- `S_GRANT` holds the address request until a grant arrives. It then moves to `S_ISSUE`, or to `S_LOAD` when the count is zero.
- `S_ISSUE` presents requests. After the last accepted element it moves to `S_FINISH` for a flat stream, or to `S_LOAD` at the next index for a chain.
- `S_FINISH` pulses `done` and returns to `S_IDLE`.

Top module: `pag_top`

## Requirements
- R1: A descriptor word is 55 bits. Its fields, from the least significant bit, are: kind in bits 1:0 (0 end, 1 linked, 2 ask, 3 flat), direction in bit 2 (1 write), local address in bits 10:3, external address in bits 26:11, count in bits 34:27, stride in bits 50:35, and next index in bits 54:51.
- R2: A flat descriptor issues exactly `count` requests. Request k has external address `ext + k*stride` (mod 2^16), local address `local + k` (mod 2^8), and the descriptor's direction.
- R3: A flat descriptor with count zero issues no request, and the walk still completes with `done`.
- R4: A linked descriptor issues its run starting at its own external address and then continues with the descriptor at its next index.
- R5: An ask descriptor raises `areq` and holds it, with no memory request, until `agnt` is high at a clock edge. The value on `agnt_addr` at that edge becomes the stream base of the run, and the walk then continues at the next index.
- R6: In a chain, the head fixes the direction and the count of every run. Its local address starts a local counter that keeps incrementing across runs. The direction, local and count fields of later descriptors have no effect.
- R7: Reaching an end descriptor terminates the walk with no further requests. A flat descriptor reached through a chain also terminates it without issuing anything.
- R8: While `mreq_valid` is high and `mreq_ready` is low, the request and its address, local address and direction stay unchanged. The walk advances only on a cycle where both are high.
- R9: `done` is high for exactly one cycle per walk, while `busy` is still high. `busy` is low in the following cycle. A start accepted in idle makes `busy` high in the next cycle.
- R10: While `busy` is high, `start` and descriptor writes are ignored. The current walk is unaffected, and a later walk sees the table as it was.
- R11: After reset, the block is idle, with `busy`, `done`, `mreq_valid` and `areq` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write strobe (idle only) |
| cfg_idx | input | 4 | Descriptor index written |
| cfg_word | input | 55 | Descriptor word written |
| start | input | 1 | Begin a walk (idle only) |
| start_idx | input | 4 | First descriptor of the walk |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | Request direction, 1 = write |
| mreq_addr | output | 16 | External element address |
| mreq_loc | output | 8 | Local element address |
| areq | output | 1 | Request for a stream base address from the compute unit |
| agnt | input | 1 | Grant of that request |
| agnt_addr | input | 16 | Stream base address carried by the grant |

## Verification
On every cycle, the bound checker checks the one-cycle `done` pulse followed by idle, and the stability of a stalled memory request. It also checks that `areq` is held until a grant, that `areq` and `mreq_valid` are never high together, and that the idle state is quiet. The exact address sequence needs the bench's scenarios. This covers strides, wrap-around, chaining through next indices, head inheritance, grant-supplied bases, and the terminating kinds. So do the effects of disturbances, such as a start or a table write while busy, which show only in a later walk.

// File: rtl/pag_pkg.sv
package pag_pkg;
    parameter int ADDR_W = 16;
    parameter int LOC_W  = 8;
    parameter int CNT_W  = 8;
    parameter int IDX_W  = 4;
    localparam int DEPTH = 1 << IDX_W;

    typedef enum logic [1:0] {
        K_END  = 2'd0,
        K_LINK = 2'd1,
        K_ASK  = 2'd2,
        K_FLAT = 2'd3
    } kind_e;

    // packed MSB first: next index at top, kind at bits 1:0
    typedef struct packed {
        logic [IDX_W-1:0]  nxt;
        logic [ADDR_W-1:0] stride;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ext;
        logic [LOC_W-1:0]  loc;
        logic              wr;
        kind_e             kind;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_GRANT,
        S_ISSUE,
        S_FINISH
    } state_e;
endpackage

// File: rtl/pag_desc_store.sv
module pag_desc_store #(
    parameter int DEPTH = 16,
    parameter int W     = 55,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/pag_stream_regs.sv
module pag_stream_regs
    import pag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  d_loc,
    input  logic              d_wr,
    input  logic [CNT_W-1:0]  d_cnt,
    input  logic [ADDR_W-1:0] d_ext,
    input  logic [ADDR_W-1:0] d_stride,
    input  logic [ADDR_W-1:0] gnt_addr,
    input  logic              head_load,
    input  logic              run_load,
    input  logic              gnt_load,
    input  logic              step,
    output logic [ADDR_W-1:0] ext_q,
    output logic [LOC_W-1:0]  loc_q,
    output logic              wr_q,
    output logic [CNT_W-1:0]  headcnt_q,
    output logic [CNT_W-1:0]  remain_q
);
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q     <= '0;
            stride_q  <= '0;
            loc_q     <= '0;
            wr_q      <= 1'b0;
            headcnt_q <= '0;
            remain_q  <= '0;
        end else begin
            if (head_load) begin
                loc_q     <= d_loc;
                wr_q      <= d_wr;
                headcnt_q <= d_cnt;
            end
            if (run_load) begin
                ext_q    <= d_ext;
                stride_q <= d_stride;
                remain_q <= head_load ? d_cnt : headcnt_q;
            end
            if (gnt_load) begin
                ext_q <= gnt_addr;
            end
            if (step) begin
                ext_q    <= ext_q + stride_q;
                loc_q    <= loc_q + 1'b1;
                remain_q <= remain_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pag_ctrl_fsm.sv
module pag_ctrl_fsm
    import pag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_idx,
    input  kind_e            d_kind,
    input  logic [CNT_W-1:0] d_cnt,
    input  logic [IDX_W-1:0] d_nxt,
    input  logic [CNT_W-1:0] headcnt,
    input  logic [CNT_W-1:0] remain,
    input  logic             mreq_ready,
    input  logic             agnt,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             done,
    output logic             mreq_valid,
    output logic             areq,
    output logic             head_load,
    output logic             run_load,
    output logic             gnt_load,
    output logic             step
);
    state_e           state, nstate;
    logic [IDX_W-1:0] cur_q, ncur;
    logic [IDX_W-1:0] next_q, nnext;
    logic             first_q, nfirst;
    logic             flat_q, nflat;
    logic [CNT_W-1:0] eff_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur_q   <= '0;
            next_q  <= '0;
            first_q <= 1'b0;
            flat_q  <= 1'b0;
        end else begin
            state   <= nstate;
            cur_q   <= ncur;
            next_q  <= nnext;
            first_q <= nfirst;
            flat_q  <= nflat;
        end
    end

    assign eff_cnt = first_q ? d_cnt : headcnt;

    // transitions and datapath controls
    always_comb begin
        nstate    = state;
        ncur      = cur_q;
        nnext     = next_q;
        nfirst    = first_q;
        nflat     = flat_q;
        head_load = 1'b0;
        run_load  = 1'b0;
        gnt_load  = 1'b0;
        step      = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nstate = S_LOAD;
                    ncur   = start_idx;
                    nfirst = 1'b1;
                    nflat  = 1'b0;
                end
            end
            S_LOAD: begin
                unique case (d_kind)
                    K_END: nstate = S_FINISH;
                    K_FLAT: begin
                        if (first_q) begin
                            head_load = 1'b1;
                            run_load  = 1'b1;
                            nflat     = 1'b1;
                            nstate    = (d_cnt == '0) ? S_FINISH : S_ISSUE;
                        end else begin
                            nstate = S_FINISH;
                        end
                    end
                    K_LINK: begin
                        head_load = first_q;
                        run_load  = 1'b1;
                        nfirst    = 1'b0;
                        nnext     = d_nxt;
                        if (eff_cnt == '0) begin
                            ncur   = d_nxt;
                            nstate = S_LOAD;
                        end else begin
                            nstate = S_ISSUE;
                        end
                    end
                    K_ASK: begin
                        head_load = first_q;
                        run_load  = 1'b1;
                        nfirst    = 1'b0;
                        nnext     = d_nxt;
                        nstate    = S_GRANT;
                    end
                endcase
            end
            S_GRANT: begin
                if (agnt) begin
                    gnt_load = 1'b1;
                    if (remain == '0) begin
                        ncur   = next_q;
                        nstate = S_LOAD;
                    end else begin
                        nstate = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                if (mreq_ready) begin
                    step = 1'b1;
                    if (remain == CNT_W'(1)) begin
                        if (flat_q) begin
                            nstate = S_FINISH;
                        end else begin
                            ncur   = next_q;
                            nstate = S_LOAD;
                        end
                    end
                end
            end
            S_FINISH: nstate = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_idx     = cur_q;
        busy       = (state != S_IDLE);
        done       = (state == S_FINISH);
        mreq_valid = (state == S_ISSUE);
        areq       = (state == S_GRANT);
    end
endmodule

// File: rtl/pag_top.sv
module pag_top
    import pag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DESC_W-1:0] cfg_word,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    output logic              busy,
    output logic              done,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic              mreq_write,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [LOC_W-1:0]  mreq_loc,
    output logic              areq,
    input  logic              agnt,
    input  logic [ADDR_W-1:0] agnt_addr
);
    logic [IDX_W-1:0]  rd_idx;
    logic [DESC_W-1:0] rd_word;
    desc_t             cur_d;
    logic              head_load, run_load, gnt_load, step;
    logic [CNT_W-1:0]  headcnt, remain;

    assign cur_d = desc_t'(rd_word);

    pag_desc_store #(.DEPTH(DEPTH), .W(DESC_W)) u_store (
        .clk   (clk),
        .we    (cfg_we && !busy),
        .widx  (cfg_idx),
        .wdata (cfg_word),
        .ridx  (rd_idx),
        .rdata (rd_word)
    );

    pag_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_idx  (start_idx),
        .d_kind     (cur_d.kind),
        .d_cnt      (cur_d.cnt),
        .d_nxt      (cur_d.nxt),
        .headcnt    (headcnt),
        .remain     (remain),
        .mreq_ready (mreq_ready),
        .agnt       (agnt),
        .rd_idx     (rd_idx),
        .busy       (busy),
        .done       (done),
        .mreq_valid (mreq_valid),
        .areq       (areq),
        .head_load  (head_load),
        .run_load   (run_load),
        .gnt_load   (gnt_load),
        .step       (step)
    );

    pag_stream_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_loc     (cur_d.loc),
        .d_wr      (cur_d.wr),
        .d_cnt     (cur_d.cnt),
        .d_ext     (cur_d.ext),
        .d_stride  (cur_d.stride),
        .gnt_addr  (agnt_addr),
        .head_load (head_load),
        .run_load  (run_load),
        .gnt_load  (gnt_load),
        .step      (step),
        .ext_q     (mreq_addr),
        .loc_q     (mreq_loc),
        .wr_q      (mreq_write),
        .headcnt_q (headcnt),
        .remain_q  (remain)
    );
endmodule

// File: rtl/pag_check.sv
module pag_check
    import pag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic              mreq_write,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic [LOC_W-1:0]  mreq_loc,
    input logic              areq,
    input logic              agnt
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_loc) && $stable(mreq_write))); // R8
    AST_ASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (areq && !agnt) |=> areq); // R5
    AST_ASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(areq && mreq_valid)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mreq_valid && !areq && !done)); // R11
endmodule

bind pag_top pag_check u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_write (mreq_write),
    .mreq_addr  (mreq_addr),
    .mreq_loc   (mreq_loc),
    .areq       (areq),
    .agnt       (agnt)
);

// File: tb/pag_top_test.sv
module pag_top_test;
    import pag_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic [LOC_W-1:0]  l;
        logic              w;
    } xfer_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [DESC_W-1:0] cfg_word = '0;
    logic              start = 1'b0;
    logic [IDX_W-1:0]  start_idx = '0;
    logic              busy, done, mreq_valid, mreq_write, areq;
    logic              mreq_ready = 1'b0;
    logic [ADDR_W-1:0] mreq_addr;
    logic [LOC_W-1:0]  mreq_loc;
    logic              agnt = 1'b0;
    logic [ADDR_W-1:0] agnt_addr = '0;

    desc_t             mm [DEPTH];
    xfer_t             exp_q [$];
    logic [ADDR_W-1:0] gq [$];
    int                gi = 0;
    int                compared = 0;
    int                mismatched = 0;
    int                done_cnt = 0;
    logic [7:0]        lfsr = 8'hA5;
    string             cur_req = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    pag_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_word   (cfg_word),
        .start      (start),
        .start_idx  (start_idx),
        .busy       (busy),
        .done       (done),
        .mreq_valid (mreq_valid),
        .mreq_ready (mreq_ready),
        .mreq_write (mreq_write),
        .mreq_addr  (mreq_addr),
        .mreq_loc   (mreq_loc),
        .areq       (areq),
        .agnt       (agnt),
        .agnt_addr  (agnt_addr)
    );

    // R1 field layout, built from the struct of the package
    function automatic desc_t mk(kind_e k, logic w, logic [LOC_W-1:0] l, logic [ADDR_W-1:0] e,
                                 logic [CNT_W-1:0] c, logic [ADDR_W-1:0] s, logic [IDX_W-1:0] n);
        desc_t d;
        d.kind = k; d.wr = w; d.loc = l; d.ext = e; d.cnt = c; d.stride = s; d.nxt = n;
        return d;
    endfunction

    task automatic check(bit ok, string what, longint act, longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
        end
    endtask

    // behavioural reference: expected request list of one walk
    task automatic build_expect(logic [IDX_W-1:0] idx0);
        desc_t             d;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] a;
        logic [LOC_W-1:0]  l;
        logic              w;
        int                cnt;
        int                g;
        xfer_t             x;
        idx = idx0;
        g = 0;
        exp_q.delete();
        d = mm[idx];
        if (d.kind == K_FLAT) begin
            a = d.ext;
            for (int i = 0; i < int'(d.cnt); i++) begin
                x.a = a; x.l = d.loc + LOC_W'(i); x.w = d.wr;
                exp_q.push_back(x);
                a = a + d.stride;
            end
        end else if (d.kind != K_END) begin
            w = d.wr; l = d.loc; cnt = int'(d.cnt);
            for (int hop = 0; hop < 64; hop++) begin
                d = mm[idx];
                if (d.kind == K_END || d.kind == K_FLAT) break;
                if (d.kind == K_LINK) a = d.ext;
                else begin a = gq[g]; g++; end
                for (int i = 0; i < cnt; i++) begin
                    x.a = a; x.l = l; x.w = w;
                    exp_q.push_back(x);
                    a = a + d.stride;
                    l = l + 1'b1;
                end
                idx = d.nxt;
            end
        end
    endtask

    // environment: ready pattern, grants, per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mreq_ready = lfsr[0] | lfsr[3];
            agnt = areq && lfsr[1];
            if (agnt) begin
                agnt_addr = (gi < gq.size()) ? gq[gi] : 16'hDEAD;
                gi++;
            end
            if (mreq_valid && mreq_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected request addr", longint'(mreq_addr), 0);
                end else begin
                    check(mreq_addr == exp_q[0].a, "addr", longint'(mreq_addr), longint'(exp_q[0].a));
                    check(mreq_loc == exp_q[0].l, "local", longint'(mreq_loc), longint'(exp_q[0].l));
                    check(mreq_write == exp_q[0].w, "dir", longint'(mreq_write), longint'(exp_q[0].w));
                    void'(exp_q.pop_front());
                end
            end
            if (done) done_cnt++;
        end
    end

    task automatic wr_desc(logic [IDX_W-1:0] i, desc_t d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_word = d;
        @(negedge clk);
        cfg_we = 1'b0;
        mm[i] = d;
    endtask

    task automatic run(logic [IDX_W-1:0] idx, string tag, bit disturb);
        int d0;
        int n;
        cur_req = tag;
        gi = 0;
        build_expect(idx);
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; start_idx = idx;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R10: start and table write while busy
            @(negedge clk);
            @(negedge clk);
            check(busy == 1'b1, "busy before disturbance", longint'(busy), 1);
            start = 1'b1; start_idx = 4'd4;
            cfg_we = 1'b1; cfg_idx = idx; cfg_word = mk(K_FLAT, 1'b1, 8'h00, 16'hBEEF, 8'd1, 16'd0, 4'd0);
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
        end
        n = 0;
        while (done_cnt == d0 && n < 3000) begin
            @(posedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "missing requests", longint'(exp_q.size()), 0);
        cur_req = {tag, " R9"};
        check(done_cnt - d0 == 1, "done pulses", longint'(done_cnt - d0), 1);
        check(busy == 1'b0, "busy after done", longint'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R11";
        check(busy == 1'b0, "reset busy", longint'(busy), 0);
        check(done == 1'b0, "reset done", longint'(done), 0);
        check(mreq_valid == 1'b0, "reset valid", longint'(mreq_valid), 0);
        check(areq == 1'b0, "reset areq", longint'(areq), 0);

        wr_desc(4'd0, mk(K_FLAT, 1'b0, 8'h10, 16'h1000, 8'd5, 16'd4, 4'd0));
        wr_desc(4'd1, mk(K_FLAT, 1'b1, 8'hFE, 16'h0008, 8'd3, 16'hFFF0, 4'd0));
        wr_desc(4'd3, mk(K_FLAT, 1'b1, 8'h00, 16'h4444, 8'd0, 16'd1, 4'd0));
        wr_desc(4'd4, mk(K_END, 1'b0, 8'h00, 16'h0000, 8'd7, 16'd1, 4'd0));
        wr_desc(4'd2, mk(K_LINK, 1'b1, 8'h40, 16'h2000, 8'd2, 16'd8, 4'd5));
        wr_desc(4'd5, mk(K_LINK, 1'b0, 8'hAA, 16'h3000, 8'd9, 16'd1, 4'd7));
        wr_desc(4'd7, mk(K_END, 1'b1, 8'h00, 16'h0000, 8'd0, 16'd0, 4'd0));
        wr_desc(4'd8, mk(K_ASK, 1'b0, 8'hFE, 16'h0000, 8'd3, 16'd2, 4'd9));
        wr_desc(4'd9, mk(K_LINK, 1'b1, 8'h11, 16'h5000, 8'd1, 16'd16, 4'd10));
        wr_desc(4'd10, mk(K_ASK, 1'b1, 8'h22, 16'h0000, 8'd0, 16'h0100, 4'd11));
        wr_desc(4'd11, mk(K_FLAT, 1'b1, 8'h33, 16'h6000, 8'd4, 16'd1, 4'd0));

        run(4'd0, "R1 R2 R8", 1'b0);
        run(4'd1, "R2", 1'b0);
        run(4'd3, "R3", 1'b0);
        run(4'd4, "R7", 1'b0);
        run(4'd2, "R4 R6", 1'b0);
        gq.delete();
        gq.push_back(16'h7000);
        gq.push_back(16'h9000);
        run(4'd8, "R5 R6 R7 R8", 1'b0);
        gq.delete();
        run(4'd0, "R10", 1'b1);
        run(4'd0, "R10", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule